// File: doc/BRIEF.md
# Configurable Logic Cell

The cell is one programmable logic element. Two 16-entry truth tables (A and B) each compute an arbitrary function of their own four select inputs. A third, 8-entry table (C) combines the A and B results with one extra input. Two registers sit behind the tables. Each register picks its own data source, clock edge, enable behaviour and preset value. Output multiplexers then choose what reaches the four outputs.

A small configuration port loads the three tables and a 16-bit mode word. A controller tracks three states:

- `ST_BLANK`: after reset, nothing has been loaded yet.
- `ST_LOAD`: configuration mode is active.
- `ST_RUN`: normal operation.

The controller moves between them through four named transitions:

- `BLANK_TO_LOAD`: the configuration-mode input rises from blank.
- `LOAD_TO_RUN`: the configuration-mode input falls.
- `RUN_TO_LOAD`: the configuration-mode input rises again.
- `STAY`: no change.

Outside `ST_RUN` both registers are held at their preset values. As a result, leaving configuration starts the logic from a known state. During operation the contents cannot change.

Typical use is to load the tables once and then treat the cell as fixed logic. For example, loading parity tables makes the cell compute the odd parity of nine inputs, and a two-level table arrangement gives any five-input function.

Top module: `cfg_logic_cell`

## Requirements
- R1: With mode bit 10 clear, `comb_a` equals table A at index `sel_a`. With mode bit 11 clear, `comb_b` equals table B at index `sel_b`.
- R2: Table C is indexed by {`sel_c`, table B result, table A result} (bit 2 down to bit 0). Mode bit 10 set routes C to `comb_a`, and mode bit 11 set routes C to `comb_b`.
- R3: On a rising `clk` edge with `cfg_mode` and `cfg_we` high, `cfg_data` is stored according to `cfg_addr`: 0 writes table A, 1 writes table B, 2 writes table C (from bits 7:0), and 3 writes the mode word.
- R4: A write strobe while `cfg_mode` is low changes no table and no mode bit.
- R5: The register data source is set by mode bits 1:0 for register A and bits 3:2 for register B. The codes are 0 for table A, 1 for table B, 2 for table C and 3 for `byp_d`.
- R6: Mode bit 4 (register A) and bit 5 (register B) set to 1 make that register capture on the falling `clk` edge instead of the rising one.
- R7: When mode bit 6 (A) or bit 7 (B) is set, the register updates only while `ce` is high and holds otherwise. When the bit is clear, it updates on every active edge.
- R8: `loc_init` or `glb_init` high at an active edge loads the preset value. The preset is mode bit 8 for A and bit 9 for B. This takes priority over the data input and over `ce`.
- R9: While the cell is not in `ST_RUN`, and at the first active edge after `cfg_mode` falls, each register takes its preset value.
- R10: Mode bit 12 (A) or bit 13 (B) set replaces the register output with a constant. The constant is mode bit 14 for A and bit 15 for B.
- R11: When tables A and B hold 4-input odd parity, table C holds 3-input odd parity and bit 10 is set, `comb_a` is the odd parity of {`sel_c`, `sel_b`, `sel_a`} for all 512 patterns.
- R12: While `rst_n` is low, the tables and mode word are cleared, the state is `ST_BLANK`, and all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; also clocks the configuration port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration target: 0 table A, 1 table B, 2 table C, 3 mode |
| cfg_data | input | 16 | Configuration data word |
| sel_a | input | 4 | Index inputs of table A |
| sel_b | input | 4 | Index inputs of table B |
| sel_c | input | 1 | Extra index bit of table C |
| byp_d | input | 1 | Direct register data input |
| ce | input | 1 | Clock enable for registers that use it |
| loc_init | input | 1 | Local synchronous preset/clear |
| glb_init | input | 1 | Global synchronous preset/clear |
| comb_a | output | 1 | Table A or table C result |
| comb_b | output | 1 | Table B or table C result |
| reg_a | output | 1 | Register A or constant |
| reg_b | output | 1 | Register B or constant |

## Verification
The hardest case to reach from the ports is a register on the inverted clock. Its capture edge falls mid-cycle, between the rising edges that drive all the other logic. The bench changes `byp_d` shortly after a rising edge. It then samples once before and once after the following falling edge, so it can show that register A moved while register B did not. Two further cases need care. One is the preset load on the exit edge from configuration, which is checked straight after `cfg_mode` falls. The other is preset priority over a low `ce`.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int LUT_IN    = 4;
    localparam int LUT_DEPTH = 1 << LUT_IN;
    localparam int CMB_IN    = 3;
    localparam int CMB_DEPTH = 1 << CMB_IN;
    localparam int CFG_W     = LUT_DEPTH;
    localparam int ADDR_W    = 2;
    localparam int NREG      = 2;

    typedef enum logic [1:0] {
        SRC_A   = 2'd0,
        SRC_B   = 2'd1,
        SRC_C   = 2'd2,
        SRC_BYP = 2'd3
    } src_e;

    typedef enum logic [ADDR_W-1:0] {
        CA_TAB_A = 2'd0,
        CA_TAB_B = 2'd1,
        CA_TAB_C = 2'd2,
        CA_MODE  = 2'd3
    } cfg_addr_e;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } state_e;

    typedef struct packed {
        logic b_fix_val;  // 15
        logic a_fix_val;  // 14
        logic b_fix;      // 13
        logic a_fix;      // 12
        logic b_pick_c;   // 11
        logic a_pick_c;   // 10
        logic b_init;     // 9
        logic a_init;     // 8
        logic b_gate;     // 7
        logic a_gate;     // 6
        logic b_inv;      // 5
        logic a_inv;      // 4
        src_e b_src;      // 3:2
        src_e a_src;      // 1:0
    } mode_t;

endpackage

// File: rtl/lcell_lut.sv
module lcell_lut #(
    parameter int IN_W = 4,
    localparam int DEPTH = 1 << IN_W
) (
    input  logic [DEPTH-1:0] table_bits,
    input  logic [IN_W-1:0]  idx,
    output logic             y
);

    assign y = table_bits[idx];

endmodule

// File: rtl/lcell_cfg.sv
module lcell_cfg
    import lcell_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_mode,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [CFG_W-1:0]     cfg_data,
    output logic [LUT_DEPTH-1:0] tab_a,
    output logic [LUT_DEPTH-1:0] tab_b,
    output logic [CMB_DEPTH-1:0] tab_c,
    output mode_t                mode,
    output logic                 run
);

    state_e state, state_nx;
    logic   wr_ok;

    // Next-state logic: BLANK_TO_LOAD, LOAD_TO_RUN, RUN_TO_LOAD, STAY
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BLANK: if (cfg_mode)  state_nx = ST_LOAD;
            ST_LOAD:  if (!cfg_mode) state_nx = ST_RUN;
            ST_RUN:   if (cfg_mode)  state_nx = ST_LOAD;
            default:                 state_nx = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BLANK;
        else        state <= state_nx;
    end

    // Output decode
    always_comb begin
        run   = (state == ST_RUN);
        wr_ok = cfg_mode && cfg_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_a <= '0;
            tab_b <= '0;
            tab_c <= '0;
            mode  <= '0;
        end else if (wr_ok) begin
            unique case (cfg_addr_e'(cfg_addr))
                CA_TAB_A: tab_a <= cfg_data[LUT_DEPTH-1:0];
                CA_TAB_B: tab_b <= cfg_data[LUT_DEPTH-1:0];
                CA_TAB_C: tab_c <= cfg_data[CMB_DEPTH-1:0];
                CA_MODE:  mode  <= mode_t'(cfg_data[$bits(mode_t)-1:0]);
                default: ;
            endcase
        end
    end

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(tab_a) && $stable(tab_b) && $stable(tab_c) && $stable(mode)));

    p_run_after_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> !$past(cfg_mode));

endmodule

// File: rtl/lcell_reg.sv
module lcell_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic inv,
    input  logic run,
    input  logic gate,
    input  logic ce,
    input  logic loc_init,
    input  logic glb_init,
    input  logic init,
    input  logic d,
    output logic q
);

    logic ck;
    logic en;

    assign ck = clk ^ inv;
    assign en = !gate || ce;

    always_ff @(posedge ck or negedge rst_n) begin
        if (!rst_n)                           q <= 1'b0;
        else if (!run || loc_init || glb_init) q <= init;
        else if (en)                          q <= d;
    end

    p_preset_r8: assert property (@(posedge ck) disable iff (!rst_n)
        (run && (loc_init || glb_init)) |=> (q == $past(init)));

    p_hold_r7: assert property (@(posedge ck) disable iff (!rst_n)
        (run && !loc_init && !glb_init && gate && !ce) |=> $stable(q));

    p_cfg_load_r9: assert property (@(posedge ck) disable iff (!rst_n)
        !run |=> (q == $past(init)));

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import lcell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [LUT_IN-1:0] sel_a,
    input  logic [LUT_IN-1:0] sel_b,
    input  logic              sel_c,
    input  logic              byp_d,
    input  logic              ce,
    input  logic              loc_init,
    input  logic              glb_init,
    output logic              comb_a,
    output logic              comb_b,
    output logic              reg_a,
    output logic              reg_b
);

    logic [LUT_DEPTH-1:0] tab_a, tab_b;
    logic [CMB_DEPTH-1:0] tab_c;
    mode_t                mode;
    logic                 run;
    logic                 fa, fb, fc;

    lcell_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .tab_a    (tab_a),
        .tab_b    (tab_b),
        .tab_c    (tab_c),
        .mode     (mode),
        .run      (run)
    );

    lcell_lut #(.IN_W(LUT_IN)) u_lut_a (.table_bits(tab_a), .idx(sel_a), .y(fa));
    lcell_lut #(.IN_W(LUT_IN)) u_lut_b (.table_bits(tab_b), .idx(sel_b), .y(fb));
    lcell_lut #(.IN_W(CMB_IN)) u_lut_c (.table_bits(tab_c), .idx({sel_c, fb, fa}), .y(fc));

    assign comb_a = mode.a_pick_c ? fc : fa;
    assign comb_b = mode.b_pick_c ? fc : fb;

    // Per-register configuration gathered into arrays
    src_e            src  [NREG];
    logic [NREG-1:0] inv, gate, init, fix, fixv, d, q, ro;

    always_comb begin
        src[0] = mode.a_src;      src[1] = mode.b_src;
        inv    = {mode.b_inv,     mode.a_inv};
        gate   = {mode.b_gate,    mode.a_gate};
        init   = {mode.b_init,    mode.a_init};
        fix    = {mode.b_fix,     mode.a_fix};
        fixv   = {mode.b_fix_val, mode.a_fix_val};
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_comb begin
            unique case (src[i])
                SRC_A:   d[i] = fa;
                SRC_B:   d[i] = fb;
                SRC_C:   d[i] = fc;
                SRC_BYP: d[i] = byp_d;
                default: d[i] = 1'b0;
            endcase
        end

        lcell_reg u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .inv      (inv[i]),
            .run      (run),
            .gate     (gate[i]),
            .ce       (ce),
            .loc_init (loc_init),
            .glb_init (glb_init),
            .init     (init[i]),
            .d        (d[i]),
            .q        (q[i])
        );

        assign ro[i] = fix[i] ? fixv[i] : q[i];
    end

    assign reg_a = ro[0];
    assign reg_b = ro[1];

    p_reset_outputs_r12: assert property (@(posedge clk)
        !rst_n |-> (!comb_a && !comb_b && !reg_a && !reg_b));

endmodule

// File: tb/sim_cfg_logic_cell.sv
`timescale 1ns/1ps
module sim_cfg_logic_cell;
    import lcell_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b0, cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic [3:0]  sel_a = '0, sel_b = '0;
    logic        sel_c = 1'b0, byp_d = 1'b0, ce = 1'b0;
    logic        loc_init = 1'b0, glb_init = 1'b0;
    logic        comb_a, comb_b, reg_a, reg_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_logic_cell u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c(sel_c), .byp_d(byp_d), .ce(ce), .loc_init(loc_init),
        .glb_init(glb_init), .comb_a(comb_a), .comb_b(comb_b),
        .reg_a(reg_a), .reg_b(reg_b)
    );

    // {tab A[16], tab B[16], tab C[8], sel_a[4], sel_b[4], sel_c, exp comb_a (C), exp comb_b (B)}
    localparam logic [50:0] VEC [8] = '{
        {16'h8000, 16'hFFFE, 8'h88, 4'hF, 4'h0, 1'b0, 1'b0, 1'b0},
        {16'h8000, 16'hFFFE, 8'h88, 4'hF, 4'h1, 1'b0, 1'b1, 1'b1},
        {16'h8000, 16'hFFFE, 8'h88, 4'hE, 4'h1, 1'b0, 1'b0, 1'b1},
        {16'h8000, 16'hFFFE, 8'hF0, 4'h0, 4'h0, 1'b1, 1'b1, 1'b0},
        {16'h6996, 16'h6996, 8'h96, 4'h7, 4'h3, 1'b0, 1'b1, 1'b0},
        {16'h6996, 16'h6996, 8'h96, 4'hF, 4'h1, 1'b1, 1'b0, 1'b1},
        {16'h8000, 16'hFFFE, 8'hCA, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0},
        {16'h8000, 16'hFFFE, 8'hCA, 4'hF, 4'h0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #3;
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [15:0] v);
        cfg_mode = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_data = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic load(input logic [15:0] ta, input logic [15:0] tb,
                        input logic [7:0] tc, input logic [15:0] md);
        cfg_wr(2'd0, ta);
        cfg_wr(2'd1, tb);
        cfg_wr(2'd2, {8'h00, tc});
        cfg_wr(2'd3, md);
        cfg_mode = 1'b0;
        tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        // R12 reset state
        repeat (2) tick();
        chk("R12 comb_a", comb_a, 1'b0);
        chk("R12 comb_b", comb_b, 1'b0);
        chk("R12 reg_a", reg_a, 1'b0);
        chk("R12 reg_b", reg_b, 1'b0);
        rst_n = 1'b1;
        tick();

        // R1 R2 R3 vector walk: comb_a shows table C, comb_b shows table B
        for (int i = 0; i < 8; i++) begin
            load(VEC[i][50:35], VEC[i][34:19], VEC[i][18:11], 16'h0400);
            sel_a = VEC[i][10:7];
            sel_b = VEC[i][6:3];
            sel_c = VEC[i][2];
            #1;
            chk("R2 R3 comb_a from table C", comb_a, VEC[i][1]);
            chk("R1 R3 comb_b from table B", comb_b, VEC[i][0]);
        end

        // R1 comb_a from table A
        load(16'h8000, 16'h0000, 8'h00, 16'h0000);
        sel_a = 4'hF; #1;
        chk("R1 comb_a A idx F", comb_a, 1'b1);
        sel_a = 4'h7; #1;
        chk("R1 comb_a A idx 7", comb_a, 1'b0);

        // R11 exhaustive nine-input parity
        load(16'h6996, 16'h6996, 8'h96, 16'h0400);
        for (int i = 0; i < 512; i++) begin
            logic [8:0] v;
            v = 9'(i);
            {sel_c, sel_b, sel_a} = v;
            #1;
            chk("R11 parity", comb_a, ^v);
        end

        // R4 writes ignored outside configuration mode
        load(16'h6996, 16'h0000, 8'h00, 16'h0000);
        sel_a = 4'h1; #1;
        chk("R4 before", comb_a, 1'b1);
        cfg_mode = 1'b0; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_data = 16'h0000;
        tick();
        cfg_addr = 2'd3; cfg_data = 16'h0400;
        tick();
        cfg_we = 1'b0; #1;
        chk("R4 table A kept", comb_a, 1'b1);
        sel_a = 4'h3; #1;
        chk("R4 mode kept", comb_a, 1'b0);

        // R5 R9 data sources and preset on exit
        byp_d = 1'b0; ce = 1'b0; loc_init = 1'b0; glb_init = 1'b0;
        load(16'h8000, 16'hFFFE, 8'h96, 16'h010B);
        chk("R9 reg_a preset 1", reg_a, 1'b1);
        chk("R9 reg_b preset 0", reg_b, 1'b0);
        sel_a = 4'h0; sel_b = 4'h0; sel_c = 1'b1; byp_d = 1'b0;
        tick();
        chk("R5 reg_a from byp_d", reg_a, 1'b0);
        chk("R5 reg_b from C", reg_b, 1'b1);
        byp_d = 1'b1; sel_c = 1'b0;
        tick();
        chk("R5 reg_a from byp_d", reg_a, 1'b1);
        chk("R5 reg_b from C", reg_b, 1'b0);

        load(16'h8000, 16'hFFFE, 8'h96, 16'h0004);
        sel_a = 4'hF; sel_b = 4'h0;
        tick();
        chk("R5 reg_a from A", reg_a, 1'b1);
        chk("R5 reg_b from B", reg_b, 1'b0);
        sel_a = 4'h0; sel_b = 4'h1;
        tick();
        chk("R5 reg_a from A", reg_a, 1'b0);
        chk("R5 reg_b from B", reg_b, 1'b1);

        // R7 clock enable
        load(16'h0000, 16'h0000, 8'h00, 16'h0043);
        byp_d = 1'b1; ce = 1'b0;
        tick();
        chk("R7 hold with ce low", reg_a, 1'b0);
        ce = 1'b1;
        tick();
        chk("R7 update with ce high", reg_a, 1'b1);
        ce = 1'b0; byp_d = 1'b0;
        tick();
        chk("R7 hold with ce low", reg_a, 1'b1);

        // R8 preset priority
        ce = 1'b0; byp_d = 1'b0;
        load(16'h0000, 16'h0000, 8'h00, 16'h0143);
        chk("R9 preset on exit", reg_a, 1'b1);
        ce = 1'b1;
        tick();
        chk("R7 data loads", reg_a, 1'b0);
        ce = 1'b0; loc_init = 1'b1;
        tick();
        chk("R8 loc_init over ce low", reg_a, 1'b1);
        loc_init = 1'b0; ce = 1'b1;
        tick();
        chk("R8 release", reg_a, 1'b0);
        glb_init = 1'b1;
        tick();
        chk("R8 glb_init over data", reg_a, 1'b1);
        glb_init = 1'b0;
        tick();
        chk("R8 release glb", reg_a, 1'b0);

        // R10 constant outputs
        ce = 1'b0; byp_d = 1'b0;
        load(16'h0000, 16'h0000, 8'h00, 16'h7000);
        chk("R10 reg_a constant 1", reg_a, 1'b1);
        chk("R10 reg_b constant 0", reg_b, 1'b0);

        // R6 inverted clock on register A only
        byp_d = 1'b0;
        load(16'h0000, 16'h0000, 8'h00, 16'h001F);
        byp_d = 1'b1;
        #1;
        chk("R6 reg_a before falling edge", reg_a, 1'b0);
        chk("R6 reg_b before falling edge", reg_b, 1'b0);
        #3;
        chk("R6 reg_a after falling edge", reg_a, 1'b1);
        chk("R6 reg_b waits for rising edge", reg_b, 1'b0);
        tick();
        chk("R6 reg_b after rising edge", reg_b, 1'b1);

        done = 1'b1;
        summary();
    end

endmodule